// File: doc/BRIEF.md
# Time-Multiplexed Word-Routing Switchbox

This block is one routing node of a coarse-grained array. It has four sides: north, east, south and west. Each side receives one incoming word bus and drives one outgoing word bus. The incoming bus of a side goes to the output multiplexers of the three other sides and never to its own side. Each multiplexer can also take the word from the local processing element. It can also take the word held in a perpendicular output register, so a word that was parked there while a channel was stalled can be put back into its own channel. Every multiplexer output is registered before it leaves the node.

The multiplexer selects are not fixed. A small context memory holds one entry per schedule slot, and each entry gives a 3-bit select for every output side. A context counter steps through the slots once per clock. It wraps after a programmable schedule length, which gives a compiled, modulo-scheduled routing pattern. Software loads the entries through a single write port. While a write is presented, the counter is held at slot 0, so the schedule starts again from slot 0 once loading ends.

Top module: `wordSwitchbox`

## Requirements
- R1: In a clock cycle with `rst` high, all four outputs are set to zero, the context counter is set to slot 0, and every context entry is set to the hold code 5. On the first edge after reset, the outputs therefore keep their zero value.
- R2: Side indices are north 0, east 1, south 2 and west 3. An entry holds the select for side d in bits [3d+2:3d]. For output side d, select codes 0, 1 and 2 choose the incoming bus of side (d+1) mod 4, (d+2) mod 4 and (d+3) mod 4.
- R3: Select code 3 chooses the local processing-element word `peIn`.
- R4: Select code 4 chooses the value that the output register of side (d+1) mod 4 held before the clock edge. This is the borrowed-register path.
- R5: Select codes 5, 6 and 7 leave the output register of that side unchanged.
- R6: Each output register takes its newly selected word at the rising edge that ends the cycle in which the select is applied. The output has one cycle of latency.
- R7: The select applied in a cycle is the entry at the current slot. In a cycle with no write, the slot moves to slot+1. If the slot is greater than or equal to `schedLenM1`, it moves to 0 instead. The schedule length is `schedLenM1`+1, from 1 to 16 slots.
- R8: While `cfgWrEn` is high, `cfgWrData` is stored at `cfgWrAddr` at the clock edge, and the slot goes to 0. During that cycle, the routing still uses the entry of the current slot as it was before the write.
- R9: With `schedLenM1` = 0, slot 0 is applied on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Context entry write strobe |
| cfgWrAddr | input | 4 | Slot that is written |
| cfgWrData | input | 12 | Entry: four 3-bit selects, one per output side |
| schedLenM1 | input | 4 | Schedule length minus one |
| peIn | input | 32 | Word from the local processing element |
| busIn | input | 4x32 | Incoming buses, indexed by side (N, E, S, W) |
| busOut | output | 4x32 | Registered outgoing buses, indexed by side |

## Verification
Assertions check the select behaviour on every cycle for every side. A hold select leaves the register stable. A borrow select copies the earlier value of the clockwise register. A processing-element select captures `peIn`. A write forces slot 0. The counter either increments or wraps at the programmed length. Other behaviours only appear when a scheduled sequence runs through a whole scenario, and only the bench's scenarios show them. These are the source side chosen by each neighbour code for each output, a mid-schedule reload restarting the pattern at slot 0, and the length-1 and full-length schedules.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int NUM_DIR = 4;
  localparam int SEL_W   = 3;
  localparam int ENTRY_W = NUM_DIR * SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_CW     = 3'd0,
    SEL_OPP    = 3'd1,
    SEL_CCW    = 3'd2,
    SEL_PE     = 3'd3,
    SEL_BORROW = 3'd4,
    SEL_HOLD   = 3'd5
  } selCode_e;

  // Strobes from control to datapath: one select per output side.
  typedef struct packed {
    logic [NUM_DIR-1:0][SEL_W-1:0] sel;
  } sboxStrobe_t;

  localparam logic [ENTRY_W-1:0] ENTRY_ALL_HOLD = {NUM_DIR{SEL_HOLD}};
endpackage

// File: rtl/sbox_ctrl.sv
module sbox_ctrl
  import sbox_pkg::*;
#(
  parameter int NUM_CTX = 16,
  localparam int CTX_AW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWrEn,
  input  logic [CTX_AW-1:0]  cfgWrAddr,
  input  logic [ENTRY_W-1:0] cfgWrData,
  input  logic [CTX_AW-1:0]  schedLenM1,
  output sboxStrobe_t        strobe
);
  typedef logic [CTX_AW-1:0] ctxIdx_t;

  logic [ENTRY_W-1:0] ctxMem [NUM_CTX];
  ctxIdx_t ctxIdx;
  ctxIdx_t ctxNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CTX; i++) ctxMem[i] <= ENTRY_ALL_HOLD;
    end else if (cfgWrEn) begin
      ctxMem[cfgWrAddr] <= cfgWrData;
    end
  end

  always_comb begin
    if (cfgWrEn)                   ctxNext = '0;
    else if (ctxIdx >= schedLenM1) ctxNext = '0;
    else                           ctxNext = ctxIdx + ctxIdx_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) ctxIdx <= '0;
    else     ctxIdx <= ctxNext;
  end

  assign strobe.sel = ctxMem[ctxIdx];

  // R8
  wr_holds_slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfgWrEn |=> (ctxIdx == '0));

  // R7
  slot_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfgWrEn && ctxIdx >= schedLenM1) |=> (ctxIdx == '0));

  // R7
  slot_steps_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfgWrEn && ctxIdx < schedLenM1) |=> (ctxIdx == ctxIdx_t'($past(ctxIdx) + ctxIdx_t'(1))));

  // R1
  rst_slot_zero_chk: assert property (@(posedge clk)
    rst |=> (ctxIdx == '0));
endmodule

// File: rtl/sbox_datapath.sv
module sbox_datapath
  import sbox_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  sboxStrobe_t                    strobe,
  input  logic [WORD_W-1:0]              peIn,
  input  logic [NUM_DIR-1:0][WORD_W-1:0] busIn,
  output logic [NUM_DIR-1:0][WORD_W-1:0] busOut
);
  for (genvar d = 0; d < NUM_DIR; d++) begin : gSide
    localparam int CW  = (d + 1) % NUM_DIR;
    localparam int OPP = (d + 2) % NUM_DIR;
    localparam int CCW = (d + 3) % NUM_DIR;

    logic [WORD_W-1:0] wordNext;
    logic [WORD_W-1:0] wordQ;

    always_comb begin
      case (strobe.sel[d])
        SEL_CW:     wordNext = busIn[CW];
        SEL_OPP:    wordNext = busIn[OPP];
        SEL_CCW:    wordNext = busIn[CCW];
        SEL_PE:     wordNext = peIn;
        SEL_BORROW: wordNext = busOut[CW];
        default:    wordNext = wordQ;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) wordQ <= '0;
      else     wordQ <= wordNext;
    end

    assign busOut[d] = wordQ;

    // R5
    hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe.sel[d] >= 3'd5) |=> $stable(busOut[d]));

    // R4
    borrow_copies_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe.sel[d] == 3'd4) |=> (busOut[d] == $past(busOut[CW])));

    // R3
    pe_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe.sel[d] == 3'd3) |=> (busOut[d] == $past(peIn)));

    // R1
    rst_clears_chk: assert property (@(posedge clk)
      rst |=> (busOut[d] == '0));
  end
endmodule

// File: rtl/wordSwitchbox.sv
module wordSwitchbox
  import sbox_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int NUM_CTX = 16,
  localparam int CTX_AW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfgWrEn,
  input  logic [CTX_AW-1:0]              cfgWrAddr,
  input  logic [ENTRY_W-1:0]             cfgWrData,
  input  logic [CTX_AW-1:0]              schedLenM1,
  input  logic [WORD_W-1:0]              peIn,
  input  logic [NUM_DIR-1:0][WORD_W-1:0] busIn,
  output logic [NUM_DIR-1:0][WORD_W-1:0] busOut
);
  sboxStrobe_t strobe;

  sbox_ctrl #(.NUM_CTX(NUM_CTX)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfgWrEn    (cfgWrEn),
    .cfgWrAddr  (cfgWrAddr),
    .cfgWrData  (cfgWrData),
    .schedLenM1 (schedLenM1),
    .strobe     (strobe)
  );

  sbox_datapath #(.WORD_W(WORD_W)) i_datapath (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .peIn   (peIn),
    .busIn  (busIn),
    .busOut (busOut)
  );
endmodule

// File: tb/test_wordSwitchbox.sv
module test_wordSwitchbox;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfgWrEn = 1'b0;
  logic [3:0]        cfgWrAddr = '0;
  logic [11:0]       cfgWrData = '0;
  logic [3:0]        schedLenM1 = '0;
  logic [31:0]       peIn = '0;
  logic [3:0][31:0]  busIn = '0;
  logic [3:0][31:0]  busOut;

  wordSwitchbox i_wordSwitchbox (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .schedLenM1(schedLenM1), .peIn(peIn),
    .busIn(busIn), .busOut(busOut)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [3:0][31:0] exp;
    string            tag;
  } item_t;

  item_t       sbQ[$];
  int          nChecks = 0;
  int          nFail = 0;
  bit          finished = 0;

  // reference model state, built from the requirements
  logic [11:0]      mMem [16];
  logic [3:0]       mCtx;
  logic [3:0][31:0] mOut;

  function automatic logic [11:0] ent(logic [2:0] n, logic [2:0] e, logic [2:0] s, logic [2:0] w);
    return {w, s, e, n};
  endfunction

  task automatic step(bit wr, logic [3:0] a, logic [11:0] dat, logic [3:0] len, string tag);
    logic [3:0][31:0] exp;
    logic [11:0] entry;
    @(negedge clk);
    cfgWrEn = wr; cfgWrAddr = a; cfgWrData = dat; schedLenM1 = len;
    peIn = $urandom;
    for (int d = 0; d < 4; d++) busIn[d] = $urandom;
    entry = mMem[mCtx];
    for (int d = 0; d < 4; d++) begin
      case (entry[3*d +: 3])
        3'd0: exp[d] = busIn[(d+1)%4];
        3'd1: exp[d] = busIn[(d+2)%4];
        3'd2: exp[d] = busIn[(d+3)%4];
        3'd3: exp[d] = peIn;
        3'd4: exp[d] = mOut[(d+1)%4];
        default: exp[d] = mOut[d];
      endcase
    end
    sbQ.push_back('{exp: exp, tag: tag});
    mOut = exp;
    if (wr) mMem[a] = dat;
    if (wr)              mCtx = 4'd0;
    else if (mCtx >= len) mCtx = 4'd0;
    else                 mCtx = mCtx + 4'd1;
  endtask

  // monitor: pops expected words after each edge
  always @(posedge clk) begin
    #2;
    if (!rst && sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      nChecks++;
      if (busOut !== it.exp) begin
        nFail++;
        $display("FAIL %s: busOut=%h expected=%h", it.tag, busOut, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nChecks++; nFail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) mMem[i] = 12'hB6D;
    mCtx = 0; mOut = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    busIn = {4{32'hDEAD_BEEF}}; peIn = 32'h1234_5678;
    @(posedge clk);
    #2;
    // R1: outputs zero after reset
    nChecks++;
    if (busOut !== '0) begin
      nFail++;
      $display("FAIL R1: busOut=%h expected=0", busOut);
    end
    @(negedge clk); rst = 0;
    // R1 R5: reset entries hold zero outputs
    repeat (4) step(0, 0, 0, 4'd3, "R1 R5 hold after reset");
    // R8: load a four-slot schedule
    step(1, 4'd0, ent(3'd0, 3'd1, 3'd2, 3'd3), 4'd3, "R8 load");
    step(1, 4'd1, ent(3'd4, 3'd4, 3'd4, 3'd4), 4'd3, "R8 load");
    step(1, 4'd2, ent(3'd5, 3'd6, 3'd7, 3'd5), 4'd3, "R8 load");
    step(1, 4'd3, ent(3'd1, 3'd2, 3'd0, 3'd3), 4'd3, "R8 load");
    // R2 R3 R4 R5 R6 R7: run the schedule
    repeat (14) step(0, 0, 0, 4'd3, "R2 R3 R4 R5 R6 R7 schedule");
    // R8: reload mid-schedule, slot goes back to 0
    step(0, 0, 0, 4'd3, "R7 advance");
    step(1, 4'd2, ent(3'd2, 3'd0, 3'd3, 3'd1), 4'd3, "R8 reload");
    repeat (9) step(0, 0, 0, 4'd3, "R8 restart at slot 0");
    // R9: length one
    repeat (6) step(0, 0, 0, 4'd0, "R9 length one");
    // R7: full sixteen-slot schedule
    step(1, 4'd15, ent(3'd3, 3'd3, 3'd3, 3'd3), 4'd15, "R8 load");
    repeat (36) step(0, 0, 0, 4'd15, "R7 full length");
    @(negedge clk); cfgWrEn = 0;
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule